// File: doc/BRIEF.md
# Indirect Packed-Word Register Bridge

The bridge gives a 32-bit host bus access to a slow internal space of 8-bit registers through one command word. A single host write to that word supplies the internal address, the byte to store and a direction flag. The bridge accepts the command, raises a busy flag and waits a fixed, parameterised number of cycles, which stands in for the handshake with the slow domain. In the last busy cycle it drives one access on its internal 8-bit register port.

Host software polls the busy flag. To read, it writes the address with the direction flag clear, waits for busy to fall, and then takes the byte from the top of the same word. To write, it checks that busy is clear and then issues one command with the direction flag set. The top byte keeps the result of the last completed read until another read completes. Host writes that arrive while an access is in flight are dropped.

Top module: `pkw_reg_bridge`

## Requirements
- R1: In a host write of the command word, bits [7:0] are the internal address, bits [15:8] are the byte to store, and bit 16 is the direction (1 = write, 0 = read). Host read-back returns the accepted values of these fields in the same positions.
- R2: A host write made while busy is low is accepted. Bit 23 (busy) reads 1 from the cycle after acceptance and stays high for exactly LATENCY cycles. It then reads 0.
- R3: A host write made while busy is high is ignored. The latched address, data and direction fields stay unchanged, and the access in flight completes with the original command at the original time.
- R4: Each accepted command produces exactly one internal port strobe (`reg_en` high for one cycle). The strobe comes in the last busy cycle, with `reg_we`, `reg_addr` and `reg_wdata` equal to the accepted direction, address and data.
- R5: When a read command completes, bits [31:24] hold the byte presented on `reg_rdata` during the strobe cycle. This value is visible in the first cycle in which busy reads 0.
- R6: Bits [31:24] keep their value until the next read completes. A completed write does not change them.
- R7: After a synchronous reset the whole command word reads 0 and no strobe is issued.
- R8: Bits [22:17] of the command word always read 0.
- R9: A command written in the first cycle after busy falls is accepted, so commands can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe for the command word |
| host_wdata | input | 32 | Host write data (packed command) |
| host_rdata | output | 32 | Command word read-back: fields, busy, read byte |
| reg_en | output | 1 | Internal port access strobe |
| reg_we | output | 1 | Internal port direction, 1 = write |
| reg_addr | output | 8 | Internal register address |
| reg_wdata | output | 8 | Byte to store in the internal register |
| reg_rdata | input | 8 | Byte returned by the internal register |

## Verification
Two events can land in the same cycle. One is a host write of the command word. The other is the completion of the access in flight, which means the strobe, the capture of the read byte and the fall of busy. The bench provokes this by issuing a second command exactly in the last busy cycle. That command must be dropped: the original fields survive, only one strobe is seen, and busy falls on time. A command issued in the very next cycle must then be accepted. Random commands also inject stray writes at random points in the busy window.

// File: rtl/pkw_pkg.sv
package pkw_pkg;
    localparam int WORD_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int BYTE_W   = 8;
    localparam int ADDR_LSB = 0;
    localparam int WDAT_LSB = ADDR_LSB + ADDR_W;
    localparam int DIR_POS  = WDAT_LSB + BYTE_W;
    localparam int BUSY_POS = 23;
    localparam int RDAT_LSB = 24;
    localparam int GAP_W    = BUSY_POS - DIR_POS - 1;

    typedef struct packed {
        logic              we;
        logic [BYTE_W-1:0] wdata;
        logic [ADDR_W-1:0] addr;
    } pkw_cmd_t;

    function automatic pkw_cmd_t unpack_cmd(input logic [WORD_W-1:0] w);
        pkw_cmd_t c;
        c.addr  = w[ADDR_LSB +: ADDR_W];
        c.wdata = w[WDAT_LSB +: BYTE_W];
        c.we    = w[DIR_POS];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] pack_status(input pkw_cmd_t c,
                                                      input logic busy,
                                                      input logic [BYTE_W-1:0] rd);
        logic [WORD_W-1:0] w;
        w = '0;
        w[ADDR_LSB +: ADDR_W] = c.addr;
        w[WDAT_LSB +: BYTE_W] = c.wdata;
        w[DIR_POS]            = c.we;
        w[BUSY_POS]           = busy;
        w[RDAT_LSB +: BYTE_W] = rd;
        return w;
    endfunction
endpackage

// File: rtl/pkw_cmd_latch.sv
module pkw_cmd_latch
    import pkw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    input  logic              busy,
    output logic              accept,
    output pkw_cmd_t          cmd_q
);
    assign accept = wr_en && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (accept) begin
            cmd_q <= unpack_cmd(wdata);
        end
    end

    // R3: a write arriving while busy leaves the latched command untouched
    p_hold_while_busy_r3: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cmd_q));
endmodule

// File: rtl/pkw_busy_timer.sv
module pkw_busy_timer #(
    parameter int LATENCY = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic last
);
    localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(LATENCY - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                cnt_q  <= CNT_INIT;
            end
        end else if (cnt_q == '0) begin
            busy_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = busy_q;
    assign last = busy_q && (cnt_q == '0);

    // R2: busy rises the cycle after an accepted start
    p_busy_after_start_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);
    // R2: busy falls right after the final busy cycle
    p_busy_ends_r2: assert property (@(posedge clk) disable iff (rst)
        last |=> !busy);
    // R2: counter never exceeds its load value
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt_q <= CNT_INIT));
endmodule

// File: rtl/pkw_rd_hold.sv
module pkw_rd_hold
    import pkw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] dout
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else if (capture) begin
            dout <= din;
        end
    end
endmodule

// File: rtl/pkw_reg_bridge.sv
module pkw_reg_bridge
    import pkw_pkg::*;
#(
    parameter int LATENCY = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr_en,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    output logic              reg_en,
    output logic              reg_we,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    input  logic [BYTE_W-1:0] reg_rdata
);
    pkw_cmd_t          cmd_q;
    logic              accept;
    logic              busy;
    logic              last;
    logic              rd_done;
    logic [BYTE_W-1:0] rd_byte;

    pkw_cmd_latch u_latch (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (host_wr_en),
        .wdata  (host_wdata),
        .busy   (busy),
        .accept (accept),
        .cmd_q  (cmd_q)
    );

    pkw_busy_timer #(.LATENCY(LATENCY)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (accept),
        .busy  (busy),
        .last  (last)
    );

    assign rd_done = last && !cmd_q.we;

    pkw_rd_hold u_rd (
        .clk     (clk),
        .rst     (rst),
        .capture (rd_done),
        .din     (reg_rdata),
        .dout    (rd_byte)
    );

    assign reg_en     = last;
    assign reg_we     = last && cmd_q.we;
    assign reg_addr   = cmd_q.addr;
    assign reg_wdata  = cmd_q.wdata;
    assign host_rdata = pack_status(cmd_q, busy, rd_byte);

    // R4: a strobe is followed by the fall of busy
    p_strobe_then_idle_r4: assert property (@(posedge clk) disable iff (rst)
        reg_en |=> !host_rdata[BUSY_POS]);
    // R4: no strobe while idle
    p_no_idle_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        !host_rdata[BUSY_POS] |-> !reg_en);
    // R5: a completed read exposes the strobe-cycle byte
    p_read_capture_r5: assert property (@(posedge clk) disable iff (rst)
        (reg_en && !reg_we) |=> host_rdata[RDAT_LSB +: BYTE_W] == $past(reg_rdata));
    // R6: without a completing read the read byte is held
    p_read_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !(reg_en && !reg_we) |=> $stable(host_rdata[RDAT_LSB +: BYTE_W]));
    // R8: reserved bits stay zero
    p_gap_zero_r8: assert property (@(posedge clk) disable iff (rst)
        host_rdata[BUSY_POS-1:DIR_POS+1] == '0);
endmodule

// File: tb/pkw_reg_bridge_tb.sv
module pkw_reg_bridge_tb_top;
    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        host_wr_en;
    logic [31:0] host_wdata;
    logic [31:0] host_rdata;
    logic        reg_en, reg_we;
    logic [7:0]  reg_addr, reg_wdata, reg_rdata;

    logic [7:0]  stub_mem [256];
    logic [7:0]  model_mem [256];
    logic [7:0]  exp_rd;
    int          strobe_cnt;
    int          n_chk;
    int          n_fail;

    always #10 clk = ~clk;

    pkw_reg_bridge #(.LATENCY(LAT)) dut_i (
        .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    assign reg_rdata = stub_mem[reg_addr];

    always @(posedge clk) begin
        if (rst) strobe_cnt <= 0;
        else if (reg_en) begin
            strobe_cnt <= strobe_cnt + 1;
            if (reg_we) stub_mem[reg_addr] <= reg_wdata;
        end
    end

    function automatic logic [31:0] mk_cmd(input logic we, input logic [7:0] a,
                                           input logic [7:0] d);
        return {15'd0, we, d, a};
    endfunction

    function automatic logic [31:0] exp_word(input logic [31:0] cmd, input logic busy,
                                             input logic [7:0] rd);
        return {rd, busy, 6'd0, cmd[16:0]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Run one command; stray = cycle index (1..LAT) for an ignored write, 0 = none
    task automatic run_cmd(input logic we, input logic [7:0] a, input logic [7:0] d,
                           input int stray);
        logic [31:0] cmd;
        int          s0;
        bit          busy_ok, field_ok, strobe_ok;
        cmd = mk_cmd(we, a, d);
        s0  = strobe_cnt;
        host_wr_en = 1'b1;
        host_wdata = cmd;
        @(negedge clk);
        host_wr_en = 1'b0;
        busy_ok = 1'b1; field_ok = 1'b1; strobe_ok = 1'b1;
        for (int k = 1; k <= LAT; k++) begin
            if (!host_rdata[23]) busy_ok = 1'b0;
            if (host_rdata[16:0] != cmd[16:0]) field_ok = 1'b0;
            if (reg_en != (k == LAT)) strobe_ok = 1'b0;
            if (k == LAT && (reg_we != we || reg_addr != a || reg_wdata != d))
                strobe_ok = 1'b0;
            if (k == stray) begin
                host_wr_en = 1'b1;
                host_wdata = mk_cmd(~we, ~a, ~d);
            end
            @(negedge clk);
            host_wr_en = 1'b0;
        end
        if (we) model_mem[a] = d;
        else    exp_rd = model_mem[a];
        check(busy_ok, "R2 busy window", host_rdata, exp_word(cmd, 1'b1, exp_rd));
        check(field_ok, (stray != 0) ? "R3 fields kept under stray write" : "R1 fields",
              host_rdata, cmd);
        check(strobe_ok, "R4 strobe timing/content", {31'd0, reg_en}, 32'd1);
        check(strobe_cnt == s0 + 1, "R4 single strobe", strobe_cnt, s0 + 1);
        check(host_rdata == exp_word(cmd, 1'b0, exp_rd),
              we ? "R6 read byte held after write" : "R5 read byte", host_rdata,
              exp_word(cmd, 1'b0, exp_rd));
        check(host_rdata[22:17] == 6'd0, "R8 reserved zero", host_rdata, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        n_chk = 0; n_fail = 0; exp_rd = 8'h00;
        void'($urandom(32'h1d5eed));
        for (int i = 0; i < 256; i++) begin
            stub_mem[i]  = 8'(i * 7 + 3);
            model_mem[i] = 8'(i * 7 + 3);
        end
        rst = 1'b1; host_wr_en = 1'b0; host_wdata = '0;
        repeat (3) @(negedge clk);
        check(host_rdata == 32'd0, "R7 reset word", host_rdata, 32'd0);
        check(reg_en == 1'b0, "R7 no strobe in reset", {31'd0, reg_en}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(host_rdata == 32'd0 && strobe_cnt == 0, "R7 idle after reset",
              host_rdata, 32'd0);

        // directed corners
        run_cmd(1'b0, 8'hFF, 8'h00, 0);       // read top address
        run_cmd(1'b1, 8'h10, 8'hA5, 0);       // write
        run_cmd(1'b0, 8'h10, 8'h00, 0);       // read it back (R9 back to back)
        run_cmd(1'b1, 8'h20, 8'h3C, 1);       // stray write in first busy cycle
        run_cmd(1'b0, 8'h20, 8'h00, LAT);     // stray write on completion cycle
        run_cmd(1'b1, 8'h00, 8'hFF, LAT);     // write at address 0, collision
        // R9: a command issued right after busy fell was accepted
        run_cmd(1'b0, 8'h00, 8'h00, 0);
        check(host_rdata[31:24] == 8'hFF, "R9 back-to-back accepted",
              host_rdata, 32'hFF000000);

        for (int i = 0; i < 60; i++) begin
            logic        we;
            logic [7:0]  a, d;
            int          st;
            we = 1'($urandom % 2);
            a  = 8'($urandom % 16);
            d  = 8'($urandom);
            st = (($urandom % 3) == 0) ? int'($urandom % LAT) + 1 : 0;
            run_cmd(we, a, d, st);
            if (($urandom % 4) == 0) @(negedge clk);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule